// File: doc/BRIEF.md
# Chip Erase and Blank Check Sequencer

This block sits on the programmer side of a byte-wide parallel non-volatile memory. On a start request it performs one full-array electrical erase and then reads every location back to confirm the device is blank. For the erase it raises two high-voltage enables, one for the output-enable pin and one for the A9 address pin, and holds chip enable low. It then drives a single long low pulse on the write strobe. Once the supervoltages are removed and a recovery interval has elapsed, it reads the whole array in ascending address order with chip enable and output enable low.

The analog supervoltage switches sit outside the block. All intervals are whole clock cycles derived from a clock-frequency parameter. The scan stops at the first byte that is not all-ones and keeps that address and data. A clean scan reports pass. An abort input removes every strobe at once and returns the block to idle. Only one erase attempt is made per start.

For a real part, the erase pulse must be set between 100 ms and 500 ms. The setup, hold and recovery intervals must each be at least 1 µs. The read window must be at least 70 ns.

Top module: `chip_erase_ctl`

## Requirements
- R1: After reset and while idle, ceN, weN and oeN are high, both high-voltage enables are low, and busy and done are low.
- R2: After a start, both high-voltage enables are high and ceN is low, with weN still high, for exactly SETUP_US*CLK_MHZ cycles before weN falls.
- R3: weN is low for exactly ERASE_US*CLK_MHZ consecutive cycles. Both high-voltage enables stay high and ceN stays low in every one of those cycles.
- R4: After weN rises, both high-voltage enables stay high for exactly HOLD_US*CLK_MHZ cycles.
- R5: After the high-voltage enables drop, oeN stays high for exactly RECOV_US*CLK_MHZ cycles before the first read.
- R6: The read-back drives memAddr from 0 upward by one. Each address is held for max(1, ceil(READ_NS*CLK_MHZ/1000)) cycles with ceN and oeN low and both high-voltage enables low. rdData is sampled in the last cycle of each window.
- R7: When every location reads 8'hFF, the scan covers all 2^ADDR_W addresses and then raises done with pass high.
- R8: The first location that does not read 8'hFF ends the scan. No higher address is driven. done rises with pass low, and failAddr and failData hold that address and byte.
- R9: While abort is high, both high-voltage enables are low and weN, ceN and oeN are high in that same cycle. The next cycle is idle with done and pass low and failAddr cleared. Abort wins over a start or a scan result arriving in the same cycle.
- R10: done, pass, failAddr and failData hold their values until the next start. A start clears done in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one erase and blank check (taken when idle or done) |
| abort | input | 1 | Stop at once and return to idle |
| rdData | input | DATA_W | Byte read from the memory data bus |
| memAddr | output | ADDR_W | Read-back address |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Logic-level output enable, active low |
| weN | output | 1 | Write strobe, active low; its low pulse is the erase |
| hvOeEn | output | 1 | Enable for the supervoltage on the output-enable pin |
| hvA9En | output | 1 | Enable for the supervoltage on the A9 pin |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | Every location read all-ones |
| failAddr | output | ADDR_W | First failing address |
| failData | output | DATA_W | Byte read at that address |

## Verification
The two functions that can fall in one cycle are the abort path and the scan's decision. The bench raises abort in the final sampling cycle of a window whose byte is bad. It expects abort to win: done and pass stay low and failAddr stays cleared instead of latching the bad address. It also raises abort in the middle of the erase pulse and checks that weN and both supervoltage enables are released in that same cycle, not one edge later.

// File: rtl/erase_pkg.sv
package erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_RECOV = 3'd4,
    ST_READ  = 3'd5,
    ST_DONE  = 3'd6
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   tmrLoad;
    phase_t tmrSel;
    logic   addrClr;
    logic   addrInc;
    logic   resClr;
    logic   resFail;
    logic   resPass;
  } ctl_t;

endpackage

// File: rtl/erase_dpath.sv
module erase_dpath
  import erase_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 100,
  parameter int ERASE_CYC = 10000000,
  parameter int HOLD_CYC  = 100,
  parameter int RECOV_CYC = 100,
  parameter int READ_CYC  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rdData,
  output logic              tmrZero,
  output logic              lastAddr,
  output logic              byteBad,
  output logic [ADDR_W-1:0] memAddr,
  output logic              passReg,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData
);

  localparam int MAX_A = (SETUP_CYC > ERASE_CYC) ? SETUP_CYC : ERASE_CYC;
  localparam int MAX_B = (HOLD_CYC > RECOV_CYC) ? HOLD_CYC : RECOV_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
  localparam int TMR_W = $clog2(MAX_CYC + 1);

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] ldVal;

  always_comb begin
    case (ctl.tmrSel)
      ST_SETUP: ldVal = TMR_W'(SETUP_CYC - 1);
      ST_PULSE: ldVal = TMR_W'(ERASE_CYC - 1);
      ST_HOLD:  ldVal = TMR_W'(HOLD_CYC - 1);
      ST_RECOV: ldVal = TMR_W'(RECOV_CYC - 1);
      ST_READ:  ldVal = TMR_W'(READ_CYC - 1);
      default:  ldVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             tmr <= '0;
    else if (ctl.tmrLoad)  tmr <= ldVal;
    else if (tmr != '0)    tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.addrClr) memAddr <= '0;
    else if (ctl.addrInc)     memAddr <= memAddr + 1'b1;
  end

  assign lastAddr = &memAddr;
  assign byteBad  = (rdData != {DATA_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN || ctl.resClr) begin
      passReg  <= 1'b0;
      failAddr <= '0;
      failData <= '0;
    end else begin
      if (ctl.resPass) passReg <= 1'b1;
      if (ctl.resFail) begin
        failAddr <= memAddr;
        failData <= rdData;
      end
    end
  end

endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic abort,
  input  logic tmrZero,
  input  logic lastAddr,
  input  logic byteBad,
  output ctl_t ctl,
  output logic ceN,
  output logic oeN,
  output logic weN,
  output logic hvOn,
  output logic busy,
  output logic done
);

  phase_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN || abort) state <= ST_IDLE;
    else                state <= nxt;
  end

  always_comb begin
    nxt = state;
    ctl = '0;
    case (state)
      ST_IDLE, ST_DONE: if (start) begin
        nxt = ST_SETUP;
        ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_SETUP; ctl.resClr = 1'b1;
      end
      ST_SETUP: if (tmrZero) begin
        nxt = ST_PULSE; ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_PULSE;
      end
      ST_PULSE: if (tmrZero) begin
        nxt = ST_HOLD; ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_HOLD;
      end
      ST_HOLD: if (tmrZero) begin
        nxt = ST_RECOV; ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_RECOV;
      end
      ST_RECOV: if (tmrZero) begin
        nxt = ST_READ; ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_READ;
        ctl.addrClr = 1'b1;
      end
      ST_READ: if (tmrZero) begin
        if (byteBad) begin
          nxt = ST_DONE; ctl.resFail = 1'b1;
        end else if (lastAddr) begin
          nxt = ST_DONE; ctl.resPass = 1'b1;
        end else begin
          ctl.addrInc = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = ST_READ;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (abort) begin
      ctl = '0;
      ctl.resClr = 1'b1;
    end
  end

  logic inErase;
  assign inErase = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);

  assign hvOn = inErase && !abort;
  assign weN  = !((state == ST_PULSE) && !abort);
  assign ceN  = !((inErase || state == ST_RECOV || state == ST_READ) && !abort);
  assign oeN  = !((state == ST_READ) && !abort);
  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/chip_erase_ctl.sv
module chip_erase_ctl
  import erase_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int ERASE_US = 100000,
  parameter int SETUP_US = 1,
  parameter int HOLD_US  = 1,
  parameter int RECOV_US = 1,
  parameter int READ_NS  = 70,
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              ceN,
  output logic              oeN,
  output logic              weN,
  output logic              hvOeEn,
  output logic              hvA9En,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData
);

  localparam int SETUP_CYC = (SETUP_US * CLK_MHZ < 1) ? 1 : SETUP_US * CLK_MHZ;
  localparam int ERASE_CYC = (ERASE_US * CLK_MHZ < 1) ? 1 : ERASE_US * CLK_MHZ;
  localparam int HOLD_CYC  = (HOLD_US * CLK_MHZ < 1) ? 1 : HOLD_US * CLK_MHZ;
  localparam int RECOV_CYC = (RECOV_US * CLK_MHZ < 1) ? 1 : RECOV_US * CLK_MHZ;
  localparam int READ_RAW  = (READ_NS * CLK_MHZ + 999) / 1000;
  localparam int READ_CYC  = (READ_RAW < 1) ? 1 : READ_RAW;

  ctl_t ctl;
  logic tmrZero, lastAddr, byteBad, hvOn;

  erase_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort),
    .tmrZero(tmrZero), .lastAddr(lastAddr), .byteBad(byteBad),
    .ctl(ctl), .ceN(ceN), .oeN(oeN), .weN(weN), .hvOn(hvOn),
    .busy(busy), .done(done)
  );

  erase_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETUP_CYC(SETUP_CYC), .ERASE_CYC(ERASE_CYC), .HOLD_CYC(HOLD_CYC),
    .RECOV_CYC(RECOV_CYC), .READ_CYC(READ_CYC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData),
    .tmrZero(tmrZero), .lastAddr(lastAddr), .byteBad(byteBad),
    .memAddr(memAddr), .passReg(pass), .failAddr(failAddr), .failData(failData)
  );

  assign hvOeEn = hvOn;
  assign hvA9En = hvOn;

endmodule

// File: rtl/erase_ctl_chk.sv
module erase_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              abort,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              hvOeEn,
  input logic              hvA9En,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [ADDR_W-1:0] failAddr,
  input logic [DATA_W-1:0] failData
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (ceN && weN && oeN && !hvOeEn && !hvA9En));

  assert_setup_before_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> ($past(hvOeEn) && $past(hvA9En) && !$past(ceN)));

  assert_pulse_under_hv_R3: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (hvOeEn && hvA9En && !ceN));

  assert_read_without_hv_R6: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (!hvOeEn && !hvA9En && !ceN && weN));

  assert_fail_byte_not_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (failData != {DATA_W{1'b1}}));

  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> (!hvOeEn && !hvA9En && weN && ceN && oeN));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && !done && !pass));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start && !abort) |=>
      (done && $stable(pass) && $stable(failAddr) && $stable(failData)));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind chip_erase_ctl erase_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .abort(abort),
  .ceN(ceN), .oeN(oeN), .weN(weN), .hvOeEn(hvOeEn), .hvA9En(hvA9En),
  .busy(busy), .done(done), .pass(pass), .failAddr(failAddr), .failData(failData)
);

// File: tb/sim_chip_erase_ctl.sv
`timescale 1ns/1ps
module sim_chip_erase_ctl;

  localparam int CLK_MHZ  = 2;
  localparam int SETUP_US = 2;
  localparam int ERASE_US = 10;
  localparam int HOLD_US  = 1;
  localparam int RECOV_US = 3;
  localparam int READ_NS  = 1500;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NADDR    = 1 << ADDR_W;
  localparam int E_SETUP  = SETUP_US * CLK_MHZ;
  localparam int E_PULSE  = ERASE_US * CLK_MHZ;
  localparam int E_HOLD   = HOLD_US * CLK_MHZ;
  localparam int E_RECOV  = RECOV_US * CLK_MHZ;
  localparam int E_READ   = (READ_NS * CLK_MHZ + 999) / 1000;
  localparam int E_PRE    = E_SETUP + E_PULSE + E_HOLD + E_RECOV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] memAddr, failAddr;
  logic [DATA_W-1:0] failData;
  logic ceN, oeN, weN, hvOeEn, hvA9En, busy, done, pass;

  always #5 clk = ~clk;

  chip_erase_ctl #(
    .CLK_MHZ(CLK_MHZ), .ERASE_US(ERASE_US), .SETUP_US(SETUP_US),
    .HOLD_US(HOLD_US), .RECOV_US(RECOV_US), .READ_NS(READ_NS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .rdData(rdData),
    .memAddr(memAddr), .ceN(ceN), .oeN(oeN), .weN(weN),
    .hvOeEn(hvOeEn), .hvA9En(hvA9En), .busy(busy), .done(done),
    .pass(pass), .failAddr(failAddr), .failData(failData)
  );

  // memory model: programmed pattern until erased, then all-ones minus stuck-at-0 bits
  logic [DATA_W-1:0] stuck [NADDR];
  logic erased = 1'b0;
  logic prevWe = 1'b1;

  always @(posedge clk) begin
    prevWe <= weN;
    if (prevWe && !weN && hvOeEn && hvA9En && !ceN) erased <= 1'b1;
  end

  assign rdData = (!ceN && !oeN)
                ? (erased ? ~stuck[memAddr] : ({memAddr, 4'h3} ^ 8'h5A))
                : 8'h00;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor
  bit monOn = 1'b0;
  bit seenPulse, hvLostInPulse, hvInRead, orderBad, runBad, seenRead;
  int setupCnt, pulseCnt, holdCnt, recovCnt, busyCnt, runLen, lastA, maxA;

  task automatic clearMon();
    seenPulse = 0; hvLostInPulse = 0; hvInRead = 0; orderBad = 0; runBad = 0;
    seenRead = 0; setupCnt = 0; pulseCnt = 0; holdCnt = 0; recovCnt = 0;
    busyCnt = 0; runLen = 0; lastA = -1; maxA = -1;
  endtask

  always @(negedge clk) if (monOn) begin
    if (busy) busyCnt++;
    if (hvOeEn && hvA9En && weN && !seenPulse) setupCnt++;
    if (!weN) begin
      pulseCnt++; seenPulse = 1;
      if (!(hvOeEn && hvA9En && !ceN)) hvLostInPulse = 1;
    end
    if (seenPulse && weN && hvOeEn && hvA9En) holdCnt++;
    if (seenPulse && busy && !hvOeEn && oeN) recovCnt++;
    if (!oeN) begin
      if (hvOeEn || hvA9En || ceN) hvInRead = 1;
      if (int'(memAddr) == lastA) runLen++;
      else begin
        if (seenRead && runLen != E_READ) runBad = 1;
        if (int'(memAddr) != lastA + 1) orderBad = 1;
        lastA = int'(memAddr); runLen = 1; seenRead = 1;
      end
      if (int'(memAddr) > maxA) maxA = int'(memAddr);
    end
  end

  task automatic clearStuck();
    for (int i = 0; i < NADDR; i++) stuck[i] = '0;
  endtask

  task automatic runErase();
    @(negedge clk);
    erased = 1'b0;
    clearMon();
    monOn = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    monOn = 1'b0;
  endtask

  initial begin
    clearStuck();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ceN && weN && oeN && !hvOeEn && !hvA9En, "R1 strobes in reset",
          {ceN, weN, oeN, hvOeEn, hvA9En}, 5'b11100);
    check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ceN && weN && oeN && !hvOeEn && !hvA9En && !busy && !done, "R1 idle after reset",
          {ceN, weN, oeN, hvOeEn, busy, done}, 6'b111000);

    // clean device
    runErase();
    check(setupCnt == E_SETUP, "R2 setup cycles", setupCnt, E_SETUP);
    check(pulseCnt == E_PULSE, "R3 pulse cycles", pulseCnt, E_PULSE);
    check(!hvLostInPulse, "R3 hv held in pulse", hvLostInPulse, 0);
    check(holdCnt == E_HOLD, "R4 hold cycles", holdCnt, E_HOLD);
    check(recovCnt == E_RECOV, "R5 recovery cycles", recovCnt, E_RECOV);
    check(!orderBad && !runBad && !hvInRead, "R6 read walk order/window",
          {orderBad, runBad, hvInRead}, 0);
    check(runLen == E_READ, "R6 last window length", runLen, E_READ);
    check(maxA == NADDR - 1, "R7 all addresses read", maxA, NADDR - 1);
    check(done && pass, "R7 pass reported", {done, pass}, 3);
    check(busyCnt == E_PRE + NADDR * E_READ, "R6 total busy cycles", busyCnt,
          E_PRE + NADDR * E_READ);
    repeat (10) @(negedge clk);
    check(done && pass && !busy, "R10 result held", {done, pass, busy}, 6);

    // single bad byte mid-array
    stuck[5] = 8'h80;
    runErase();
    check(done && !pass, "R8 fail reported", {done, pass}, 2);
    check(failAddr == 4'd5, "R8 fail address", failAddr, 5);
    check(failData == 8'h7F, "R8 fail data", failData, 8'h7F);
    check(maxA == 5, "R8 scan stopped", maxA, 5);
    check(busyCnt == E_PRE + 6 * E_READ, "R8 busy cycles to stop", busyCnt, E_PRE + 6 * E_READ);
    clearStuck();

    // boundary: first and last address
    stuck[0] = 8'h01;
    runErase();
    check(done && !pass && failAddr == 0 && failData == 8'hFE, "R8 fail at address 0",
          failAddr, 0);
    clearStuck();
    stuck[NADDR-1] = 8'h10;
    runErase();
    check(done && !pass && failAddr == 4'(NADDR-1) && failData == 8'hEF,
          "R8 fail at last address", failAddr, NADDR - 1);
    clearStuck();

    // two bad bytes: first one reported
    stuck[3] = 8'h02; stuck[9] = 8'h40;
    runErase();
    check(failAddr == 4'd3 && failData == 8'hFD, "R8 first failure wins", failAddr, 3);
    check(maxA == 3, "R8 no address past first failure", maxA, 3);
    clearStuck();

    // restart clears done
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done && busy, "R10 start clears done", {done, busy}, 1);
    // abort during pulse
    for (int i = 0; i < 200 && weN; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    #1;
    check(!hvOeEn && !hvA9En && weN && ceN && oeN, "R9 release same cycle",
          {hvOeEn, hvA9En, weN, ceN, oeN}, 5'b00111);
    @(negedge clk);
    abort = 1'b0;
    check(!busy && !done && !pass, "R9 idle after abort", {busy, done, pass}, 0);

    // start and abort together: abort wins
    start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check(!busy && !done, "R9 abort beats start", {busy, done}, 0);

    // abort in the very cycle a bad byte is judged
    stuck[5] = 8'h80;
    erased = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000 && !(!oeN && memAddr == 4'd5); i++) @(negedge clk);
    repeat (E_READ - 1) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(!done && !pass && !busy, "R9 abort beats fail latch", {done, pass, busy}, 0);
    check(failAddr == 0, "R9 fail address cleared", failAddr, 0);
    clearStuck();

    // clean run after aborts
    runErase();
    check(done && pass && pulseCnt == E_PULSE, "R7 pass after aborts", pulseCnt, E_PULSE);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule